// File: doc/BRIEF.md
# Accumulator Add Instruction Decoder

This block decodes and executes the add family of an 8-bit accumulator CPU: add with carry, add without carry, signed-immediate adjust of the 16-bit stack pointer, and signed-immediate adjust of the 16-bit index pair. An opcode enters on `opcode_i`, with a one-bit `pfx_i` that marks a preceding stack-relative prefix byte. The operand byte that the fetch logic has already resolved arrives on `operand_i`. The block reports the addressing mode, the number of operand bytes after the opcode, and the instruction's cycle count.

Within the same cycle, an 8-bit adder forms the new accumulator and the flags. Two 16-bit sign-extending adders form the adjusted pointers. Every output is registered, and all state updates one clock after `valid_i`.

Memory access and operand fetch are handled elsewhere. The block only decides and computes.

Top module: `addx_exec`

## Requirements
- R1: Synchronous active-high reset sets `done_o`=0, `illegal_o`=0, `mode_o`=0, `nbytes_o`=0, `ncyc_o`=0, `acc_o`=0, `sp_o`=16'h00FF, `hx_o`=0 and `ccr_o`=0.
- R2: With `pfx_i`=0, add-with-carry opcodes x9 and add-without-carry opcodes xB decode by high nibble as follows:
  - A: `mode_o`=1 (immediate), 1 byte, 2 cycles.
  - B: mode 2 (direct), 1 byte, 3 cycles.
  - C: mode 3 (extended), 2 bytes, 4 cycles.
  - D: mode 4 (16-bit indexed offset), 2 bytes, 4 cycles.
  - E: mode 5 (8-bit indexed offset), 1 byte, 3 cycles.
  - F: mode 6 (indexed, no offset), 0 bytes, 2 cycles.
- R3: With `pfx_i`=1, E9/EB decode to mode 7 (8-bit stack offset), 1 byte, 4 cycles. D9/DB decode to mode 8 (16-bit stack offset), 2 bytes, 5 cycles.
- R4: With `pfx_i`=0, A7 (stack pointer adjust) and AF (index pair adjust) decode to mode 1, 1 byte, 2 cycles.
- R5: Add with carry sets the accumulator to A + M + C. Add without carry sets it to A + M. M is `operand_i`, C is `ccr_o[0]`, and the sum is taken modulo 256.
- R6: An accumulator add writes `ccr_o` as {V,H,N,Z,C}, bit 4 down to bit 0:
  - C is the carry out of bit 7.
  - H is the carry out of bit 3.
  - N is result bit 7.
  - Z is set when the result is zero.
  - V is set when both addends share a sign and the result sign differs.
- R7: A7 adds the sign-extended operand to `sp_o`, and AF adds it to `hx_o`, modulo 2^16. Neither changes `ccr_o` or `acc_o`.
- R8: Any other opcode, or the prefix followed by anything but D9/DB/E9/EB, sets `illegal_o`=1 and `mode_o`/`nbytes_o`/`ncyc_o`=0. The accumulator, pointers and flags stay unchanged.
- R9: Results appear on the clock edge after `valid_i`, with `done_o` high for that one cycle. While `valid_i`=0, the state is unchanged and `done_o`=0; `illegal_o`, `mode_o`, `nbytes_o` and `ncyc_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | An instruction is presented this cycle |
| pfx_i | input | 1 | Stack-relative prefix byte preceded the opcode |
| opcode_i | input | 8 | Opcode byte |
| operand_i | input | 8 | Memory operand or signed immediate |
| done_o | output | 1 | Instruction retired last cycle |
| illegal_o | output | 1 | Last instruction was not a supported add |
| mode_o | output | 4 | Addressing mode code |
| nbytes_o | output | 2 | Operand bytes following the opcode |
| ncyc_o | output | 3 | Instruction cycle count |
| acc_o | output | 8 | Accumulator |
| sp_o | output | 16 | Stack pointer |
| hx_o | output | 16 | Index pair |
| ccr_o | output | 5 | Flags {V,H,N,Z,C} |

## Verification
The hardest case to reach is an add with carry whose incoming carry decides both the half-carry and the overflow. That needs a previous add that left C set and an operand sitting exactly on the 4-bit and 8-bit boundaries. The stimulus chains directed adds: first it sets carry, then it adds operands such as 0x0F and 0x7F so that the stored carry tips H and V. After that, a long pseudo-random run picks legal and illegal opcodes with and without the prefix. Every output is compared with a behavioural model on every clock.

// File: rtl/addx_pkg.sv
package addx_pkg;
  typedef enum logic [3:0] {
    AM_NONE = 4'd0,
    AM_IMM  = 4'd1,
    AM_DIR  = 4'd2,
    AM_EXT  = 4'd3,
    AM_IX2  = 4'd4,
    AM_IX1  = 4'd5,
    AM_IX   = 4'd6,
    AM_SP1  = 4'd7,
    AM_SP2  = 4'd8
  } amode_e;

  typedef enum logic [1:0] {
    OK_NONE  = 2'd0,
    OK_ACC   = 2'd1,
    OK_SPADJ = 2'd2,
    OK_HXADJ = 2'd3
  } opkind_e;

  typedef struct packed {
    opkind_e    kind;
    logic       use_carry;
    amode_e     mode;
    logic [1:0] nbytes;
    logic [2:0] ncyc;
    logic       illegal;
  } dec_t;

  localparam int CCR_W = 5;
endpackage

// File: rtl/addx_decode.sv
module addx_decode
  import addx_pkg::*;
(
  input  logic       pfx_i,
  input  logic [7:0] op_i,
  output dec_t       dec_o
);
  logic [3:0] hi, lo;
  assign hi = op_i[7:4];
  assign lo = op_i[3:0];

  always_comb begin
    dec_o = '0;
    dec_o.kind    = OK_NONE;
    dec_o.mode    = AM_NONE;
    dec_o.illegal = 1'b1;
    if (lo == 4'h9 || lo == 4'hB) begin
      dec_o.use_carry = (lo == 4'h9);
      case ({pfx_i, hi})
        {1'b0, 4'hA}: begin dec_o.mode = AM_IMM; dec_o.nbytes = 2'd1; dec_o.ncyc = 3'd2; end
        {1'b0, 4'hB}: begin dec_o.mode = AM_DIR; dec_o.nbytes = 2'd1; dec_o.ncyc = 3'd3; end
        {1'b0, 4'hC}: begin dec_o.mode = AM_EXT; dec_o.nbytes = 2'd2; dec_o.ncyc = 3'd4; end
        {1'b0, 4'hD}: begin dec_o.mode = AM_IX2; dec_o.nbytes = 2'd2; dec_o.ncyc = 3'd4; end
        {1'b0, 4'hE}: begin dec_o.mode = AM_IX1; dec_o.nbytes = 2'd1; dec_o.ncyc = 3'd3; end
        {1'b0, 4'hF}: begin dec_o.mode = AM_IX;  dec_o.nbytes = 2'd0; dec_o.ncyc = 3'd2; end
        {1'b1, 4'hE}: begin dec_o.mode = AM_SP1; dec_o.nbytes = 2'd1; dec_o.ncyc = 3'd4; end
        {1'b1, 4'hD}: begin dec_o.mode = AM_SP2; dec_o.nbytes = 2'd2; dec_o.ncyc = 3'd5; end
        default: ;
      endcase
      if (dec_o.mode != AM_NONE) begin
        dec_o.kind    = OK_ACC;
        dec_o.illegal = 1'b0;
      end else begin
        dec_o.use_carry = 1'b0;
      end
    end else if (!pfx_i && (op_i == 8'hA7 || op_i == 8'hAF)) begin
      dec_o.kind    = (op_i == 8'hA7) ? OK_SPADJ : OK_HXADJ;
      dec_o.mode    = AM_IMM;
      dec_o.nbytes  = 2'd1;
      dec_o.ncyc    = 3'd2;
      dec_o.illegal = 1'b0;
    end
  end

  // R8
  always_comb begin
    legal_has_mode_chk: assert (dec_o.illegal == (dec_o.kind == OK_NONE));
  end
endmodule

// File: rtl/addx_alu.sv
module addx_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output logic         v_o,
  output logic         h_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;

  assign full = {1'b0, a_i} + {1'b0, m_i} + {{W{1'b0}}, cin_i};
  assign half = {1'b0, a_i[HW-1:0]} + {1'b0, m_i[HW-1:0]} + {{HW{1'b0}}, cin_i};

  assign r_o = full[W-1:0];
  assign c_o = full[W];
  assign h_o = half[HW];
  assign n_o = full[W-1];
  assign z_o = (full[W-1:0] == '0);
  assign v_o = (a_i[W-1] == m_i[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/addx_ptradj.sv
module addx_ptradj #(
  parameter int PW = 16,
  parameter int W  = 8
) (
  input  logic [PW-1:0] base_i,
  input  logic [W-1:0]  imm_i,
  output logic [PW-1:0] sum_o
);
  localparam int XW = PW - W;
  assign sum_o = base_i + {{XW{imm_i[W-1]}}, imm_i};
endmodule

// File: rtl/addx_exec.sv
module addx_exec
  import addx_pkg::*;
#(
  parameter int          W      = 8,
  parameter int          PW     = 16,
  parameter logic [15:0] SP_RST = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             pfx_i,
  input  logic [7:0]       opcode_i,
  input  logic [W-1:0]     operand_i,
  output logic             done_o,
  output logic             illegal_o,
  output logic [3:0]       mode_o,
  output logic [1:0]       nbytes_o,
  output logic [2:0]       ncyc_o,
  output logic [W-1:0]     acc_o,
  output logic [PW-1:0]    sp_o,
  output logic [PW-1:0]    hx_o,
  output logic [CCR_W-1:0] ccr_o
);
  localparam int NPTR = 2;

  dec_t dec;
  addx_decode u_dec (.pfx_i(pfx_i), .op_i(opcode_i), .dec_o(dec));

  logic [W-1:0] sum;
  logic v, h, n, z, c;
  addx_alu #(.W(W)) u_alu (
    .a_i(acc_o), .m_i(operand_i), .cin_i(dec.use_carry & ccr_o[0]),
    .r_o(sum), .v_o(v), .h_o(h), .n_o(n), .z_o(z), .c_o(c)
  );

  logic [PW-1:0] ptr_base [NPTR];
  logic [PW-1:0] ptr_sum  [NPTR];
  assign ptr_base[0] = sp_o;
  assign ptr_base[1] = hx_o;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    addx_ptradj #(.PW(PW), .W(W)) u_adj (
      .base_i(ptr_base[g]), .imm_i(operand_i), .sum_o(ptr_sum[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      mode_o    <= '0;
      nbytes_o  <= '0;
      ncyc_o    <= '0;
      acc_o     <= '0;
      sp_o      <= SP_RST[PW-1:0];
      hx_o      <= '0;
      ccr_o     <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        illegal_o <= dec.illegal;
        mode_o    <= dec.mode;
        nbytes_o  <= dec.nbytes;
        ncyc_o    <= dec.ncyc;
        case (dec.kind)
          OK_ACC: begin
            acc_o <= sum;
            ccr_o <= {v, h, n, z, c};
          end
          OK_SPADJ: sp_o <= ptr_sum[0];
          OK_HXADJ: hx_o <= ptr_sum[1];
          default: ;
        endcase
      end
    end
  end

  // R8
  illegal_state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dec.illegal) |=> (illegal_o && $stable(acc_o) && $stable(sp_o)
                                  && $stable(hx_o) && $stable(ccr_o)));
  // R7
  ptr_flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (dec.kind == OK_SPADJ || dec.kind == OK_HXADJ))
      |=> ($stable(ccr_o) && $stable(acc_o)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!done_o && $stable(acc_o) && $stable(sp_o) && $stable(hx_o)
                  && $stable(ccr_o) && $stable(mode_o)));
  // R6
  zn_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dec.kind == OK_ACC)
      |=> ((ccr_o[1] == (acc_o == '0)) && (ccr_o[2] == acc_o[W-1])));
  // R2
  cycle_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o) |-> (ncyc_o >= 3'd2 && ncyc_o <= 3'd5 && nbytes_o <= 2'd2));
endmodule

// File: tb/tb_addx_exec.sv
module tb_addx_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic        pfx_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  operand_i = '0;
  logic        done_o, illegal_o;
  logic [3:0]  mode_o;
  logic [1:0]  nbytes_o;
  logic [2:0]  ncyc_o;
  logic [7:0]  acc_o;
  logic [15:0] sp_o, hx_o;
  logic [4:0]  ccr_o;

  addx_exec dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .pfx_i(pfx_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .done_o(done_o), .illegal_o(illegal_o), .mode_o(mode_o),
    .nbytes_o(nbytes_o), .ncyc_o(ncyc_o), .acc_o(acc_o), .sp_o(sp_o), .hx_o(hx_o),
    .ccr_o(ccr_o)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_done = 0, m_ill = 0, m_mode = 0, m_nb = 0, m_cyc = 0;
  int m_acc = 0, m_sp = 255, m_hx = 0, m_ccr = 0;
  string dtag = "R2";

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit v, bit p, int op, int opd);
    int kind;
    m_done = v;
    if (!v) return;
    kind = 0;
    dtag = p ? "R3" : "R2";
    case ({p, op[7:0]})
      9'h0A9, 9'h0AB: begin m_mode = 1; m_nb = 1; m_cyc = 2; kind = 1; end
      9'h0B9, 9'h0BB: begin m_mode = 2; m_nb = 1; m_cyc = 3; kind = 1; end
      9'h0C9, 9'h0CB: begin m_mode = 3; m_nb = 2; m_cyc = 4; kind = 1; end
      9'h0D9, 9'h0DB: begin m_mode = 4; m_nb = 2; m_cyc = 4; kind = 1; end
      9'h0E9, 9'h0EB: begin m_mode = 5; m_nb = 1; m_cyc = 3; kind = 1; end
      9'h0F9, 9'h0FB: begin m_mode = 6; m_nb = 0; m_cyc = 2; kind = 1; end
      9'h1E9, 9'h1EB: begin m_mode = 7; m_nb = 1; m_cyc = 4; kind = 1; end
      9'h1D9, 9'h1DB: begin m_mode = 8; m_nb = 2; m_cyc = 5; kind = 1; end
      9'h0A7: begin m_mode = 1; m_nb = 1; m_cyc = 2; kind = 2; dtag = "R4"; end
      9'h0AF: begin m_mode = 1; m_nb = 1; m_cyc = 2; kind = 3; dtag = "R4"; end
      default: begin m_mode = 0; m_nb = 0; m_cyc = 0; kind = 0; dtag = "R8"; end
    endcase
    m_ill = (kind == 0);
    if (kind == 1) begin
      int ci, s, hs, r, fv, fh, fn, fz, fc;
      ci = ((op & 15) == 9) ? (m_ccr & 1) : 0;
      s  = m_acc + opd + ci;
      hs = (m_acc & 15) + (opd & 15) + ci;
      r  = s & 255;
      fc = (s > 255);
      fh = (hs > 15);
      fn = (r > 127);
      fz = (r == 0);
      fv = (((m_acc ^ opd) & 128) == 0) && (((m_acc ^ r) & 128) != 0);
      m_acc = r;
      m_ccr = (fv << 4) | (fh << 3) | (fn << 2) | (fz << 1) | fc;
    end else if (kind >= 2) begin
      int sx;
      sx = (opd > 127) ? opd - 256 : opd;
      if (kind == 2) m_sp = (m_sp + sx + 65536) & 65535;
      else           m_hx = (m_hx + sx + 65536) & 65535;
    end
  endtask

  task automatic compare_all();
    check("R9", "done", int'(done_o), m_done);
    check("R8", "illegal", int'(illegal_o), m_ill);
    check(dtag, "mode", int'(mode_o), m_mode);
    check(dtag, "nbytes", int'(nbytes_o), m_nb);
    check(dtag, "ncyc", int'(ncyc_o), m_cyc);
    check("R5", "acc", int'(acc_o), m_acc);
    check("R7", "sp", int'(sp_o), m_sp);
    check("R7", "hx", int'(hx_o), m_hx);
    check("R6", "ccr", int'(ccr_o), m_ccr);
  endtask

  // called at a negedge; drives, then compares at the next negedge
  task automatic step(bit v, bit p, int op, int opd);
    valid_i   = v;
    pfx_i     = p;
    opcode_i  = op[7:0];
    operand_i = opd[7:0];
    model(v, p, op, opd);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lcg;
    int ops [22];
    ops = '{32'hA9, 32'hB9, 32'hC9, 32'hD9, 32'hE9, 32'hF9, 32'hAB, 32'hBB, 32'hCB,
            32'hDB, 32'hEB, 32'hFB, 32'hA7, 32'hAF, 32'h00, 32'hE8, 32'h9E, 32'hA9,
            32'hEB, 32'hD9, 32'hA7, 32'h4C};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "done", int'(done_o), 0);
    check("R1", "illegal", int'(illegal_o), 0);
    check("R1", "mode", int'(mode_o), 0);
    check("R1", "acc", int'(acc_o), 0);
    check("R1", "sp", int'(sp_o), 16'h00FF);
    check("R1", "hx", int'(hx_o), 0);
    check("R1", "ccr", int'(ccr_o), 0);
    step(0, 0, 0, 0);
    // R5 R6: overflow and half carry
    step(1, 0, 'hAB, 'h7F);   // 0x7F
    step(1, 0, 'hAB, 'h01);   // 0x80 V H N
    step(1, 0, 'hBB, 'h80);   // 0x00 V C Z
    step(1, 0, 'hA9, 'h0F);   // carry in: 0x10, H
    step(1, 0, 'hCB, 'hF0);   // 0x00 C Z
    step(1, 0, 'hB9, 'h7F);   // carry in: 0x80 V H N
    step(1, 0, 'hD9, 'h80);   // 0x00 V C Z
    step(1, 0, 'hE9, 'hFF);   // carry in to 0xFF+1 -> 0x00 C Z H
    step(0, 1, 'hA9, 'h55);   // R9 idle ignores inputs
    step(1, 0, 'hF9, 'h12);
    step(1, 0, 'hEB, 'h34);
    step(1, 0, 'hDB, 'h56);
    step(1, 0, 'hFB, 'h78);
    // R3 prefixed forms
    step(1, 1, 'hE9, 'h01);
    step(1, 1, 'hEB, 'h02);
    step(1, 1, 'hD9, 'h03);
    step(1, 1, 'hDB, 'h04);
    // R4 R7 pointer adjusts
    step(1, 0, 'hA7, 'h80);
    step(1, 0, 'hA7, 'h7F);
    step(1, 0, 'hAF, 'hFF);
    step(1, 0, 'hAF, 'h10);
    // R8 illegal forms
    step(1, 0, 'h00, 'h11);
    step(1, 1, 'hA9, 'h22);
    step(1, 1, 'hA7, 'h33);
    step(1, 1, 'hF9, 'h44);
    step(1, 0, 'hE8, 'h55);
    step(0, 0, 0, 0);
    lcg = 12345;
    for (int i = 0; i < 400; i++) begin
      int k, opd;
      bit p, v;
      lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
      k   = (lcg >> 8) % 22;
      opd = (lcg >> 3) & 255;
      p   = ((lcg >> 20) & 7) == 0;
      v   = ((lcg >> 24) & 7) != 0;
      step(v, p, ops[k], opd);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule